// File: doc/BRIEF.md
# Video DRAM Cycle-Type Decoder

This block watches the control pins of a dual-port video DRAM and tells the rest of the controller which kind of access is under way. It brings every strobe, control level and the multiplexed address into one system clock through a two-flop synchronizer. It then finds the falling and rising edges of the row strobe and the falling edge of the column strobe on the synchronized copies.

When the row strobe falls, the block latches the row address and fixes the access type from the transfer, write/mask and serial-enable levels. It reports that type on a one-hot output, which holds until the row strobe rises. The later column-strobe fall latches the address bus again. For an ordinary access that value is a column address; for a transfer it is the serial register start pointer. The same column edge can still turn a read into a late write and can mark a block write.

When the row strobe rises, the type clears and a single-cycle completion pulse marks the end of the access. A data-output enable follows the strobes during read accesses, so the controller can drive the array's output buffers.

Top module: `vram_cycle_decoder`

## Requirements
- R1: After reset, `cycle_type_o`, `row_addr_o`, `col_addr_o`, `persist_mask_o`, `block_wr_o`, `cycle_done_o` and `dq_oe_o` are all zero.
- R2: On every row-strobe fall, `row_addr_o` takes the value of `addr_i`, and it keeps that value until the next row-strobe fall.
- R3: When the transfer/output-enable input is low at the row-strobe fall, the access is a transfer. It is a read transfer (bit 3) if the write/mask input is high. If the write/mask input is low, it is a write transfer (bit 4) when serial-enable is low, and a serial-input-mode enable (bit 5) when serial-enable is high.
- R4: When the transfer/output-enable input is high at the row-strobe fall, the access is a DRAM access. It is a masked write (bit 2) if the write/mask input is low and a read (bit 0) otherwise. At most one bit of `cycle_type_o` is ever set.
- R5: In a read access, a low write/mask input at the column-strobe fall changes the type to write (bit 1).
- R6: A column-strobe fall loads `addr_i` into `col_addr_o` only while an access is active (`cycle_type_o` non-zero). A column-strobe fall at any other time leaves `col_addr_o` unchanged.
- R7: `persist_mask_o` is set when the special-function select is high at the row-strobe fall of a masked write.
- R8: `block_wr_o` is set when the special-function select is high at the column-strobe fall of a write or masked write.
- R9: The type holds until the row strobe rises. On that rise, the type, `persist_mask_o` and `block_wr_o` clear, and `cycle_done_o` pulses high for exactly one cycle if an access was active.
- R10: `dq_oe_o` is high only during a read access, and only while the row strobe, the column strobe and the transfer/output-enable input are all low.
- R11: If the column strobe is already low when the row strobe falls, no access is classified and no completion pulse follows. The row address is still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_strb_ni | input | 1 | Row address strobe, active low |
| col_strb_ni | input | 1 | Column address strobe, active low |
| xfer_oe_ni | input | 1 | Transfer select at row fall, output enable afterwards, active low |
| wr_mask_ni | input | 1 | Write/mask select, active low |
| ser_en_ni | input | 1 | Serial-enable, active low |
| spec_sel_i | input | 1 | Special-function select |
| addr_i | input | 9 | Multiplexed row / column / serial start address |
| row_addr_o | output | 9 | Latched row address |
| col_addr_o | output | 9 | Latched column address or serial start pointer |
| cycle_type_o | output | 6 | One-hot type: 0 read, 1 write, 2 masked write, 3 read transfer, 4 write transfer, 5 serial-input enable |
| persist_mask_o | output | 1 | Persistent masked write selected |
| block_wr_o | output | 1 | Block write selected |
| cycle_done_o | output | 1 | One-cycle pulse at the end of an access |
| dq_oe_o | output | 1 | Data output enable for reads |

## Verification
Two synchronizer stages, the edge register and the capture register stand between a pin change and each registered result. The latched addresses, the type, both mode flags and the completion pulse therefore appear on the third rising clock edge after the edge that first sees the pin. `dq_oe_o` appears one edge earlier, because it is formed from the synchronized levels.

The bench changes pins only on falling clock edges and holds each strobe phase for six cycles before it samples on a falling edge, so every result has settled. The completion pulse is counted across an eight-cycle window after each row-strobe rise, which shows it is exactly one cycle wide.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  localparam int unsigned CT_W  = 6;
  localparam int unsigned CT_RD = 0;
  localparam int unsigned CT_WR = 1;
  localparam int unsigned CT_MW = 2;
  localparam int unsigned CT_RT = 3;
  localparam int unsigned CT_WT = 4;
  localparam int unsigned CT_SI = 5;

  typedef logic [CT_W-1:0] ctype_t;

  // Type fixed at the row-strobe fall from the active-low control levels.
  function automatic ctype_t decode_row(input logic xfer_n, input logic wr_n,
                                        input logic se_n);
    ctype_t t;
    t = '0;
    if (!xfer_n) begin
      if (wr_n)      t[CT_RT] = 1'b1;
      else if (!se_n) t[CT_WT] = 1'b1;
      else           t[CT_SI] = 1'b1;
    end else begin
      if (!wr_n) t[CT_MW] = 1'b1;
      else       t[CT_RD] = 1'b1;
    end
    return t;
  endfunction
endpackage

// File: rtl/vcd_sync.sv
module vcd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/vcd_edge.sv
module vcd_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
  assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/vcd_classify.sv
module vcd_classify
  import vcd_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          row_fall_i,
  input  logic          row_rise_i,
  input  logic          col_fall_i,
  input  logic          col_lvl_i,
  input  logic          xfer_n_i,
  input  logic          wr_n_i,
  input  logic          se_n_i,
  input  logic          spec_i,
  input  logic [AW-1:0] addr_i,
  output ctype_t        type_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          persist_o,
  output logic          block_o,
  output logic          done_o
);
  ctype_t        type_q, type_d;
  logic [AW-1:0] row_q, row_d, col_q, col_d;
  logic          pers_q, pers_d, blk_q, blk_d, done_q, done_d;
  logic          active;

  assign active = |type_q;

  always_comb begin
    type_d = type_q;
    row_d  = row_q;
    col_d  = col_q;
    pers_d = pers_q;
    blk_d  = blk_q;
    done_d = 1'b0;
    if (row_fall_i) begin
      row_d  = addr_i;
      blk_d  = 1'b0;
      if (col_lvl_i) begin
        type_d = decode_row(xfer_n_i, wr_n_i, se_n_i);
        pers_d = spec_i & xfer_n_i & ~wr_n_i;
      end else begin
        type_d = '0;
        pers_d = 1'b0;
      end
    end else if (row_rise_i) begin
      type_d = '0;
      pers_d = 1'b0;
      blk_d  = 1'b0;
      done_d = active;
    end else if (col_fall_i && active) begin
      col_d = addr_i;
      if (type_q[CT_RD] && !wr_n_i) begin
        type_d        = '0;
        type_d[CT_WR] = 1'b1;
      end
      blk_d = spec_i & (type_d[CT_WR] | type_d[CT_MW]);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      pers_q <= 1'b0;
      blk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      type_q <= type_d;
      row_q  <= row_d;
      col_q  <= col_d;
      pers_q <= pers_d;
      blk_q  <= blk_d;
      done_q <= done_d;
    end
  end

  assign type_o    = type_q;
  assign row_o     = row_q;
  assign col_o     = col_q;
  assign persist_o = pers_q;
  assign block_o   = blk_q;
  assign done_o    = done_q;
endmodule

// File: rtl/vram_cycle_decoder.sv
module vram_cycle_decoder
  import vcd_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          row_strb_ni,
  input  logic          col_strb_ni,
  input  logic          xfer_oe_ni,
  input  logic          wr_mask_ni,
  input  logic          ser_en_ni,
  input  logic          spec_sel_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] row_addr_o,
  output logic [AW-1:0] col_addr_o,
  output logic [CT_W-1:0] cycle_type_o,
  output logic          persist_mask_o,
  output logic          block_wr_o,
  output logic          cycle_done_o,
  output logic          dq_oe_o
);
  localparam int unsigned NCTL = 6;
  localparam int unsigned SW   = NCTL + AW;
  localparam logic [SW-1:0] SYNC_RST = {{(NCTL-1){1'b1}}, 1'b0, {AW{1'b0}}};

  // Reset: asserted at once, released through two flops.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [SW-1:0] raw_vec, syn_vec;
  logic          ras_s, cas_s, xfer_s, wr_s, se_s, spec_s;
  logic [AW-1:0] addr_s;

  assign raw_vec = {row_strb_ni, col_strb_ni, xfer_oe_ni, wr_mask_ni,
                    ser_en_ni, spec_sel_i, addr_i};

  vcd_sync #(.W(SW), .RST_VAL(SYNC_RST)) sync_i (
    .clk(clk), .rst_ni(rst_sync_q), .d_i(raw_vec), .q_o(syn_vec)
  );

  assign {ras_s, cas_s, xfer_s, wr_s, se_s, spec_s, addr_s} = syn_vec;

  logic row_fall, row_rise, col_fall, col_rise_unused;

  vcd_edge #(.RST_VAL(1'b1)) ras_edge_i (
    .clk(clk), .rst_ni(rst_sync_q), .lvl_i(ras_s),
    .fall_o(row_fall), .rise_o(row_rise)
  );

  vcd_edge #(.RST_VAL(1'b1)) cas_edge_i (
    .clk(clk), .rst_ni(rst_sync_q), .lvl_i(cas_s),
    .fall_o(col_fall), .rise_o(col_rise_unused)
  );

  ctype_t type_w;

  vcd_classify #(.AW(AW)) cls_i (
    .clk(clk), .rst_ni(rst_sync_q),
    .row_fall_i(row_fall), .row_rise_i(row_rise), .col_fall_i(col_fall),
    .col_lvl_i(cas_s), .xfer_n_i(xfer_s), .wr_n_i(wr_s), .se_n_i(se_s),
    .spec_i(spec_s), .addr_i(addr_s),
    .type_o(type_w), .row_o(row_addr_o), .col_o(col_addr_o),
    .persist_o(persist_mask_o), .block_o(block_wr_o), .done_o(cycle_done_o)
  );

  assign cycle_type_o = type_w;
  assign dq_oe_o      = type_w[CT_RD] & ~ras_s & ~cas_s & ~xfer_s;
endmodule

// File: rtl/vcd_checker.sv
module vcd_checker #(
  parameter int unsigned AW = 9,
  parameter int unsigned TW = 6
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          row_fall,
  input logic          row_rise,
  input logic          col_fall,
  input logic [AW-1:0] row_addr_o,
  input logic [AW-1:0] col_addr_o,
  input logic [TW-1:0] cycle_type_o,
  input logic          cycle_done_o,
  input logic          dq_oe_o
);
  a_r4_type_onehot: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(cycle_type_o));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    cycle_done_o |=> !cycle_done_o);

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    cycle_done_o |-> (cycle_type_o == '0));

  a_r9_type_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!row_fall && !row_rise && !col_fall) |=> $stable(cycle_type_o));

  a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !row_fall |=> $stable(row_addr_o));

  a_r6_col_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(col_fall && (cycle_type_o != '0)) |=> $stable(col_addr_o));

  a_r10_oe_read: assert property (@(posedge clk) disable iff (!rst_ni)
    dq_oe_o |-> cycle_type_o[0]);
endmodule

bind vram_cycle_decoder vcd_checker #(.AW(AW), .TW(vcd_pkg::CT_W)) chk_i (
  .clk(clk), .rst_ni(rst_ni), .row_fall(row_fall), .row_rise(row_rise),
  .col_fall(col_fall), .row_addr_o(row_addr_o), .col_addr_o(col_addr_o),
  .cycle_type_o(cycle_type_o), .cycle_done_o(cycle_done_o), .dq_oe_o(dq_oe_o)
);

// File: tb/vram_cycle_decoder_tb_top.sv
module vram_cycle_decoder_tb_top;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       ras_n, cas_n, xfer_n, wr_n, se_n, spec;
  logic [8:0] addr;
  logic [8:0] row_addr, col_addr;
  logic [5:0] ctype;
  logic       persist, block, done, dq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [8:0] exp_col = '0;

  always #4 clk = ~clk;

  vram_cycle_decoder dut_i (
    .clk(clk), .rst_ni(rst_ni), .row_strb_ni(ras_n), .col_strb_ni(cas_n),
    .xfer_oe_ni(xfer_n), .wr_mask_ni(wr_n), .ser_en_ni(se_n),
    .spec_sel_i(spec), .addr_i(addr), .row_addr_o(row_addr),
    .col_addr_o(col_addr), .cycle_type_o(ctype), .persist_mask_o(persist),
    .block_wr_o(block), .cycle_done_o(done), .dq_oe_o(dq_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_row_type(input logic xf, input logic wr,
                                               input logic se);
    if (!xf) return wr ? 6'b001000 : (!se ? 6'b010000 : 6'b100000);
    return wr ? 6'b000001 : 6'b000100;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_cycle(input logic xf, input logic wr_r, input logic se_r,
                           input logic sp_r, input logic wr_c, input logic sp_c,
                           input logic oe_c, input logic cas_first,
                           input logic [8:0] ra, input logic [8:0] ca);
    logic [5:0] t_row, t_fin;
    int pulses;
    t_row = cas_first ? 6'b0 : exp_row_type(xf, wr_r, se_r);
    addr = ra; xfer_n = xf; wr_n = wr_r; se_n = se_r; spec = sp_r;
    cas_n = cas_first ? 1'b0 : 1'b1;
    wait_n(2);
    ras_n = 1'b0;
    wait_n(HOLD);
    check("R2 row address", row_addr, ra);
    check(cas_first ? "R11 no type" : "R3/R4 row type", ctype, t_row);
    check("R7 persistent mask", persist, (t_row[2] && sp_r) ? 1 : 0);
    t_fin = t_row;
    if (!cas_first) begin
      addr = ca; wr_n = wr_c; spec = sp_c; xfer_n = oe_c;
      wait_n(2);
      cas_n = 1'b0;
      wait_n(HOLD);
      if (t_row[0] && !wr_c) t_fin = 6'b000010;
      exp_col = ca;
      check("R5 final type", ctype, t_fin);
      check("R8 block write", block, ((t_fin[1] || t_fin[2]) && sp_c) ? 1 : 0);
      check("R10 dq_oe", dq_oe, (t_fin[0] && !oe_c) ? 1 : 0);
    end
    check("R6 column address", col_addr, exp_col);
    ras_n = 1'b1; cas_n = 1'b1; xfer_n = 1'b1; wr_n = 1'b1;
    pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check(cas_first ? "R11 no done" : "R9 done pulse", pulses, cas_first ? 0 : 1);
    check("R9 type cleared", ctype, 0);
    check("R10 dq_oe off", dq_oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_ni = 1'b0;
    ras_n = 1; cas_n = 1; xfer_n = 1; wr_n = 1; se_n = 1; spec = 0; addr = '0;
    wait_n(4);
    // R1 reset state
    check("R1 type", ctype, 0);
    check("R1 row", row_addr, 0);
    check("R1 col", col_addr, 0);
    check("R1 flags", {persist, block, done, dq_oe}, 0);
    rst_ni = 1'b1;
    wait_n(4);

    // Directed corners: every type, address extremes
    run_cycle(1, 1, 1, 0, 1, 0, 0, 0, 9'h000, 9'h1FF); // read with OE
    run_cycle(1, 1, 1, 0, 0, 1, 1, 0, 9'h1FF, 9'h000); // late write, block
    run_cycle(1, 0, 1, 1, 0, 1, 1, 0, 9'h0AA, 9'h155); // masked, persist, block
    run_cycle(0, 1, 1, 0, 1, 0, 1, 0, 9'h123, 9'h0FF); // read transfer
    run_cycle(0, 0, 0, 0, 0, 0, 1, 0, 9'h100, 9'h0FF); // write transfer
    run_cycle(0, 0, 1, 0, 0, 0, 1, 0, 9'h0FF, 9'h100); // serial input enable
    run_cycle(1, 1, 1, 0, 1, 0, 0, 1, 9'h077, 9'h000); // R11 column first

    // R6: column fall with no access leaves col_addr alone
    addr = 9'h1A5; wait_n(2); cas_n = 1'b0; wait_n(HOLD);
    check("R6 idle column ignored", col_addr, exp_col);
    check("R6 idle no type", ctype, 0);
    cas_n = 1'b1; wait_n(HOLD);

    for (int k = 0; k < 60; k++) begin
      logic [9:0] r;
      r = 10'($urandom);
      run_cycle(r[0], r[1], r[2], r[3], r[4], r[5], r[6], (r[9:7] == 3'd0),
                9'($urandom), 9'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule